// File: doc/BRIEF.md
# Mask and Integer Conversion Unit

This block converts between a B-bit unsigned integer and a mask of N = 2^B-1 bits, in either direction, for two mask styles. A point mask carries at most one set bit. A monotone mask is a run of zeros in the low bits followed by ones that reach the top bit. Positions count from 1 at the least significant bit. The value zero is kept to mean "no bit set", which is why the all-ones integer maps onto the top mask bit.

A 2-bit mode input selects one of the four conversions. The conversion logic is combinational. The result is captured in an output register together with a valid flag, so a result appears one cycle after the request. Integer inputs are read from the low B bits of the shared N-bit data input. Integer results are returned zero-extended in the low B bits of the N-bit data output.

Inputs with several isolated set bits are outside the supported mask forms. For those inputs the output is deterministic but is not specified.

Top module: `mask_conv`

## Requirements
- R1: With mode_i = 2'b00 (point to integer), a data_i with only bit k set, where k counts from 1 at the LSB, yields the integer k in data_o[B-1:0], and the upper bits of data_o are zero.
- R2: With mode_i = 2'b01 (integer to point), an integer i > 0 on data_i[B-1:0] yields a data_o in which only bit i is set. The bits of data_i above bit B-1 have no effect.
- R3: An all-zero mask in mode 2'b00 or 2'b10 yields integer 0. Integer 0 in mode 2'b01 or 2'b11 yields an all-zero mask.
- R4: With mode_i = 2'b11 (integer to monotone), an integer i > 0 yields a mask whose bits i through N are one and whose bits 1 through i-1 are zero. The bits of data_i above bit B-1 have no effect.
- R5: With mode_i = 2'b10 (monotone to integer), a monotone mask yields the 1-based position of its lowest set bit. The all-ones mask gives 1 and a mask with only the top bit set gives N.
- R6: valid_o equals the value in_valid_i had at the previous rising clock edge.
- R7: data_o keeps its value across any edge at which in_valid_i is low.
- R8: While rst_ni is low, data_o and valid_o are zero, immediately and independently of the clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe; loads the output register |
| mode_i | input | 2 | Conversion select: 00 point→int, 01 int→point, 10 monotone→int, 11 int→monotone |
| data_i | input | 2^B-1 | Mask input, or integer input in the low B bits |
| data_o | output | 2^B-1 | Registered mask, or zero-extended integer result |
| valid_o | output | 1 | Result valid, one cycle after in_valid_i |

## Verification
The bench sweeps every legal input of all four modes at B = 4 and works out each expected value with shifts in the bench. Four edge values get particular attention.

The empty mask and integer zero must not alias position 1. A converter off by one would return 1 for an empty mask, or set bit 0 for integer 0.

The all-ones integer must reach the top mask bit. A decoder sized 2^B would lose it or shift it.

The all-ones monotone mask must decode to 1 and not to N. Logic that encodes the highest set bit instead of the lowest would give N.

Stray bits above the integer field are driven in the integer-to-mask modes. A design that read the full data word would produce a corrupted mask. The bench also holds in_valid_i low while the inputs change, to confirm data_o stays put, and pulses reset between clock edges to catch a reset that waits for the clock.

// File: rtl/mask_conv_pkg.sv
package mask_conv_pkg;
  typedef enum logic [1:0] {
    MODE_PT2INT   = 2'b00,
    MODE_INT2PT   = 2'b01,
    MODE_MONO2INT = 2'b10,
    MODE_INT2MONO = 2'b11
  } conv_mode_e;
endpackage

// File: rtl/mask_pos_enc.sv
// Position encoder: output bit j is the OR of every mask bit whose 1-based index has bit j set.
module mask_pos_enc #(
  parameter int INT_W  = 4,
  parameter int MASK_W = (1 << INT_W) - 1
) (
  input  logic [MASK_W-1:0] mask_i,
  output logic [INT_W-1:0]  pos_o
);
  for (genvar j = 0; j < INT_W; j++) begin : g_bit
    logic [MASK_W-1:0] sel;
    for (genvar k = 1; k <= MASK_W; k++) begin : g_k
      if (((k >> j) & 1) == 1) begin : g_on
        assign sel[k-1] = mask_i[k-1];
      end else begin : g_off
        assign sel[k-1] = 1'b0;
      end
    end
    assign pos_o[j] = |sel;
  end
endmodule

// File: rtl/mask_pt_dec.sv
module mask_pt_dec #(
  parameter int INT_W  = 4,
  parameter int MASK_W = (1 << INT_W) - 1
) (
  input  logic [INT_W-1:0]  pos_i,
  output logic [MASK_W-1:0] mask_o
);
  for (genvar k = 1; k <= MASK_W; k++) begin : g_k
    assign mask_o[k-1] = (pos_i == INT_W'(k));
  end
endmodule

// File: rtl/mask_mono_gen.sv
module mask_mono_gen #(
  parameter int INT_W  = 4,
  parameter int MASK_W = (1 << INT_W) - 1
) (
  input  logic [INT_W-1:0]  pos_i,
  output logic [MASK_W-1:0] mask_o
);
  logic nz;
  assign nz = |pos_i;
  for (genvar k = 1; k <= MASK_W; k++) begin : g_k
    assign mask_o[k-1] = nz && (INT_W'(k) >= pos_i);
  end
endmodule

// File: rtl/mask_mono_enc.sv
// Isolate the lowest set bit (set here, clear below), then encode it.
module mask_mono_enc #(
  parameter int INT_W  = 4,
  parameter int MASK_W = (1 << INT_W) - 1
) (
  input  logic [MASK_W-1:0] mask_i,
  output logic [INT_W-1:0]  pos_o
);
  logic [MASK_W-1:0] shl;
  logic [MASK_W-1:0] edge_m;

  assign shl    = {mask_i[MASK_W-2:0], 1'b0};
  assign edge_m = mask_i & ~shl;

  mask_pos_enc #(.INT_W(INT_W), .MASK_W(MASK_W)) enc_i (
    .mask_i (edge_m),
    .pos_o  (pos_o)
  );
endmodule

// File: rtl/mask_conv.sv
module mask_conv
  import mask_conv_pkg::*;
#(
  parameter int INT_W  = 4,
  localparam int MASK_W = (1 << INT_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [1:0]        mode_i,
  input  logic [MASK_W-1:0] data_i,
  output logic [MASK_W-1:0] data_o,
  output logic              valid_o
);
  logic [INT_W-1:0]  int_w;
  logic [INT_W-1:0]  pt_pos_w;
  logic [INT_W-1:0]  mono_pos_w;
  logic [MASK_W-1:0] pt_mask_w;
  logic [MASK_W-1:0] mono_mask_w;
  logic [MASK_W-1:0] next_w;
  conv_mode_e        mode_w;

  assign int_w  = data_i[INT_W-1:0];
  assign mode_w = conv_mode_e'(mode_i);

  mask_pos_enc #(.INT_W(INT_W), .MASK_W(MASK_W)) pt_enc_i (
    .mask_i (data_i),
    .pos_o  (pt_pos_w)
  );

  mask_mono_enc #(.INT_W(INT_W), .MASK_W(MASK_W)) mono_enc_i (
    .mask_i (data_i),
    .pos_o  (mono_pos_w)
  );

  mask_pt_dec #(.INT_W(INT_W), .MASK_W(MASK_W)) pt_dec_i (
    .pos_i  (int_w),
    .mask_o (pt_mask_w)
  );

  mask_mono_gen #(.INT_W(INT_W), .MASK_W(MASK_W)) mono_gen_i (
    .pos_i  (int_w),
    .mask_o (mono_mask_w)
  );

  always_comb begin
    unique case (mode_w)
      MODE_PT2INT:   next_w = MASK_W'(pt_pos_w);
      MODE_INT2PT:   next_w = pt_mask_w;
      MODE_MONO2INT: next_w = MASK_W'(mono_pos_w);
      MODE_INT2MONO: next_w = mono_mask_w;
      default:       next_w = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= in_valid_i;
      if (in_valid_i) data_o <= next_w;
    end
  end

  // R2
  pt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pt_mask_w));

  // R4
  mono_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (({mono_mask_w[MASK_W-2:0], 1'b0} & ~mono_mask_w) == '0));

  // R4
  mono_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mono_mask_w != '0) |-> mono_mask_w[MASK_W-1]);

  // R3
  empty_pt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mode_i == 2'b00 && data_i == '0) |=> (data_o == '0));

  // R6
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> valid_o);

  // R6
  valid_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !valid_o);

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(data_o));
endmodule

// File: tb/mask_conv_tb_top.sv
`timescale 1ns/1ps
module mask_conv_tb_top;
  localparam int INT_W  = 4;
  localparam int MASK_W = (1 << INT_W) - 1;
  localparam logic [MASK_W-1:0] ALL = '1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              vld = 1'b0;
  logic [1:0]        mode = 2'b00;
  logic [MASK_W-1:0] din = '0;
  logic [MASK_W-1:0] dout;
  logic              vout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mask_conv #(.INT_W(INT_W)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (vld),
    .mode_i     (mode),
    .data_i     (din),
    .data_o     (dout),
    .valid_o    (vout)
  );

  task automatic chk(input logic ok, input string tag,
                     input logic [MASK_W-1:0] act, input logic [MASK_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [MASK_W-1:0] pt_of(input int i);
    return (i == 0) ? '0 : MASK_W'(1) << (i - 1);
  endfunction

  function automatic logic [MASK_W-1:0] mono_of(input int i);
    return (i == 0) ? '0 : (ALL >> (i - 1)) << (i - 1);
  endfunction

  task automatic run(input logic [1:0] m, input logic [MASK_W-1:0] d,
                     input logic [MASK_W-1:0] exp, input string tag);
    @(negedge clk);
    mode = m; din = d; vld = 1'b1;
    @(negedge clk);
    chk(dout === exp, tag, dout, exp);
    chk(vout === 1'b1, "R6 valid high", MASK_W'(vout), MASK_W'(1));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dout === '0, "R8 reset data", dout, '0);
    chk(vout === 1'b0, "R8 reset valid", MASK_W'(vout), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R3 point to integer
    for (int i = 0; i <= MASK_W; i++)
      run(2'b00, pt_of(i), MASK_W'(i), (i == 0) ? "R3 empty point" : "R1 point to int");

    // R2 / R3 integer to point, junk in upper bits must be ignored
    for (int i = 0; i <= MASK_W; i++) begin
      run(2'b01, MASK_W'(i), pt_of(i), (i == 0) ? "R3 zero to point" : "R2 int to point");
      run(2'b01, MASK_W'(i) | (ALL << INT_W), pt_of(i), "R2 upper bits ignored");
    end

    // R5 / R3 monotone to integer
    for (int i = 0; i <= MASK_W; i++)
      run(2'b10, mono_of(i), MASK_W'(i), (i == 0) ? "R3 empty mono" : "R5 mono to int");
    run(2'b10, ALL, MASK_W'(1), "R5 all ones gives 1");
    run(2'b10, MASK_W'(1) << (MASK_W - 1), MASK_W'(MASK_W), "R5 top only gives N");

    // R4 / R3 integer to monotone
    for (int i = 0; i <= MASK_W; i++) begin
      run(2'b11, MASK_W'(i), mono_of(i), (i == 0) ? "R3 zero to mono" : "R4 int to mono");
      run(2'b11, MASK_W'(i) | (ALL << INT_W), mono_of(i), "R4 upper bits ignored");
    end

    // R7 hold while idle, R6 valid drops
    run(2'b01, MASK_W'(5), pt_of(5), "R2 int to point");
    @(negedge clk);
    vld = 1'b0; mode = 2'b11; din = MASK_W'(2);
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      chk(dout === pt_of(5), "R7 hold", dout, pt_of(5));
      chk(vout === 1'b0, "R6 valid low", MASK_W'(vout), '0);
    end

    // R8 asynchronous reset between edges
    run(2'b11, MASK_W'(1), ALL, "R4 int to mono");
    #1 rst_n = 1'b0;
    #1 chk(dout === '0, "R8 async data", dout, '0);
    chk(vout === 1'b0, "R8 async valid", MASK_W'(vout), '0);
    vld = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dout === '0, "R8 after release", dout, '0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule